// File: doc/BRIEF.md
# Sixteen-bit timer/counter with compare and capture

This block is a peripheral timer for a small controller. A sixteen-bit counter advances on a prescaled tick strobe or on a chosen edge of an external clock pin. It can run freely, run as a single ramp up to a programmable ceiling, or run as a ramp that climbs to the ceiling and descends back to zero. Two compare channels hold a written value and an active value. A match against the active value raises a flag and shapes that channel's waveform output. A capture unit samples the count on a rising edge from one of two pins or from a comparator event strobe, and can optionally filter that edge for noise.

Software reaches the block through a single-cycle register port with a combinational read path. Four event flags (overflow, match A, match B, capture) stay set until software clears them, and a mask register chooses which of them raise the interrupt line. The prescaler and the comparator sit outside the block; only their strobes enter it.

Top module: `tmr16_top`

## Requirements
- R1: Register addresses are 0 control, 1 count, 2 compare A, 3 compare B, 4 capture (read only), 5 flags, 6 mask. After synchronous reset every register reads 0 and wave_a, wave_b and irq are low.
- R2: Control bits [2:0] select the count source: 0 none, 1 one step per cycle with tick_in high, 2 one step per rising edge of ext_clk_pin, 3 one step per falling edge of ext_clk_pin, 4 to 7 none. The external pin passes two synchronizer flops before edge detection. With no source the count holds.
- R3: Control bits [4:3] = 0 (normal, code 3 acts the same) count up from 0xFFFF to 0. A step taken at 0xFFFF sets flag bit 0. Compare writes take effect at once.
- R4: Mode 1 (single ramp) counts up. A step taken while the count is at or above the active compare A value returns the count to 0 and sets flag bit 0.
- R5: Mode 2 (up/down) counts up to the active compare A value, turns, and counts down to 0. A step taken at 0 while descending turns upward, steps to 1 and sets flag bit 0. A write to the count register sets the direction to up.
- R6: In modes 1 and 2 a compare write lands in a buffer. The buffer moves to the active value on the step that wraps to 0 (mode 1) or turns at the ceiling (mode 2).
- R7: A step taken while the count equals a channel's active value sets flag bit 1 (channel A) or flag bit 2 (channel B).
- R8: A channel's waveform toggles on each match in normal mode. In mode 1 it goes high on the wrap step and low on a match, and the wrap wins when both occur. In mode 2 it goes low on a match while counting up and high on a match while counting down. Any control write drives both waveforms low.
- R9: Control bit 6 = 1 selects cmp_evt_in as the capture source; otherwise bit 5 picks cap_pin_a (0) or cap_pin_b (1). A synchronized rising edge of the source copies the count into the capture register and sets flag bit 3.
- R10: With control bit 7 set, a capture edge is accepted only after the synchronized source has held its new level for four consecutive clocks. Shorter pulses are ignored.
- R11: Writing 1 to a flag bit clears it. A set event in the same cycle as a clear leaves the bit set.
- R12: irq is high exactly while some flag bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| tick_in | input | 1 | Prescaled tick strobe |
| ext_clk_pin | input | 1 | External count pin |
| cap_pin_a | input | 1 | Capture pin A |
| cap_pin_b | input | 1 | Capture pin B |
| cmp_evt_in | input | 1 | Comparator event level |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench drives each counting mode across its turning points: 0xFFFF to 0 in normal mode, the ceiling wrap in mode 1, and both reversals in mode 2. A counter that wrapped one step early or late, or that took the wrong direction after a count write, lands on a different final count. A ceiling change written mid-ramp must not act until the wrap, so a design with immediate compare loading wraps at the new value and ends elsewhere. The bench also lands a flag clear in the same cycle as a match, sends pulses to the pin that is not selected, and sends two-cycle glitches through the filter. A design with the wrong priority loses the flag, and one with a faulty mux or filter captures when it should not.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int CW = 16;
    localparam int RW = 8;
    localparam int AW = 3;
    localparam int NCH = 2;
    localparam int NFLAG = 4;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_COUNT = 3'd1;
    localparam logic [AW-1:0] A_CMPA  = 3'd2;
    localparam logic [AW-1:0] A_CMPB  = 3'd3;
    localparam logic [AW-1:0] A_CAPT  = 3'd4;
    localparam logic [AW-1:0] A_FLAGS = 3'd5;
    localparam logic [AW-1:0] A_MASK  = 3'd6;

    localparam int F_OVF = 0;
    localparam int F_MA  = 1;
    localparam int F_MB  = 2;
    localparam int F_CAP = 3;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_SLOPE  = 2'd1,
        M_DUAL   = 2'd2,
        M_ALT    = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      filt;
        logic      cmp_en;
        logic      pin_sel;
        tmr_mode_e mode;
        logic [2:0] clk_sel;
    } tmr_ctrl_t;

    typedef struct packed {
        logic ovf;
        logic wrap;
        logic load;
    } tmr_cnt_evt_t;

    function automatic logic is_buffered(input tmr_mode_e m);
        return (m == M_SLOPE) || (m == M_DUAL);
    endfunction

    function automatic logic [CW-1:0] ceiling(input tmr_mode_e m, input logic [CW-1:0] cmpa);
        return is_buffered(m) ? cmpa : CNT_MAX;
    endfunction
endpackage

// File: rtl/tmr_clk_sel.sv
`timescale 1ns/1ps
module tmr_clk_sel #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    input  logic       tick,
    input  logic       ext_pin,
    output logic       step
);
    logic [SYNC:0] sh;
    logic cur, prev;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-1:0], ext_pin};
    end

    assign cur  = sh[SYNC-1];
    assign prev = sh[SYNC];

    always_comb begin
        case (sel)
            3'd1:    step = tick;
            3'd2:    step = cur & ~prev;
            3'd3:    step = ~cur & prev;
            default: step = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
    import tmr_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top,
    input  logic         step,
    input  logic         set_wr,
    input  logic [W-1:0] set_val,
    output logic [W-1:0] cnt,
    output logic         up,
    output tmr_cnt_evt_t evt
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] nxt;
    logic         nxt_up;
    logic         at_top;

    assign at_top = (cnt >= top);

    always_comb begin
        nxt    = cnt + ONE;
        nxt_up = up;
        evt    = '0;
        case (mode)
            M_SLOPE: begin
                if (at_top) begin
                    nxt      = '0;
                    evt.ovf  = step;
                    evt.wrap = step;
                    evt.load = step;
                end
            end
            M_DUAL: begin
                if (up) begin
                    if (at_top) begin
                        nxt      = (cnt == '0) ? '0 : cnt - ONE;
                        nxt_up   = 1'b0;
                        evt.load = step;
                    end
                end else begin
                    if (cnt == '0) begin
                        nxt     = (top == '0) ? '0 : ONE;
                        nxt_up  = 1'b1;
                        evt.ovf = step;
                    end else begin
                        nxt = cnt - ONE;
                    end
                end
            end
            default: begin
                evt.ovf = step && (cnt == FULL);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (set_wr) begin
            cnt <= set_val;
            up  <= 1'b1;
        end else if (step) begin
            cnt <= nxt;
            up  <= nxt_up;
        end
    end
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_mode_e    mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic         wrap,
    input  logic         load,
    input  logic         wave_clr,
    output logic [W-1:0] held,
    output logic [W-1:0] act,
    output logic         match,
    output logic         wave
);
    assign match = step && (cnt == act);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            act  <= '0;
        end else begin
            if (wr) held <= wdata;
            if (wr && !is_buffered(mode)) act <= wdata;
            else if (load)                act <= held;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wave_clr) begin
            wave <= 1'b0;
        end else begin
            case (mode)
                M_SLOPE: begin
                    if (wrap)       wave <= 1'b1;
                    else if (match) wave <= 1'b0;
                end
                M_DUAL: begin
                    if (match) wave <= ~up;
                end
                default: begin
                    if (match) wave <= ~wave;
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int W        = CW,
    parameter int SYNC     = 2,
    parameter int FILT_LEN = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin_sel,
    input  logic         cmp_en,
    input  logic         filt,
    input  logic         pin_a,
    input  logic         pin_b,
    input  logic         cmp_evt,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] capt,
    output logic         hit
);
    logic                src;
    logic [SYNC-1:0]     sh;
    logic                s;
    logic [FILT_LEN-2:0] hist;
    logic [FILT_LEN-1:0] window;
    logic                lvl, lvl_n, steady;

    assign src    = cmp_en ? cmp_evt : (pin_sel ? pin_b : pin_a);
    assign s      = sh[SYNC-1];
    assign window = {hist, s};
    assign steady = (&window) | ~(|window);
    assign lvl_n  = filt ? (steady ? s : lvl) : s;
    assign hit    = lvl_n & ~lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            hist <= '0;
            lvl  <= 1'b0;
            capt <= '0;
        end else begin
            sh   <= {sh[SYNC-2:0], src};
            hist <= {hist[FILT_LEN-3:0], s};
            lvl  <= lvl_n;
            if (hit) capt <= cnt;
        end
    end
endmodule

// File: rtl/tmr16_top.sv
`timescale 1ns/1ps
module tmr16_top
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          tick_in,
    input  logic          ext_clk_pin,
    input  logic          cap_pin_a,
    input  logic          cap_pin_b,
    input  logic          cmp_evt_in,
    output logic          wave_a,
    output logic          wave_b,
    output logic          irq
);
    tmr_ctrl_t        ctrl_q;
    logic [NFLAG-1:0] flags_q, mask_q, flag_set, flag_clr;
    logic [CW-1:0]    cnt, capt;
    logic             up, step, cap_hit;
    logic             ctrl_wr, cnt_wr, flag_wr, mask_wr;
    tmr_cnt_evt_t     cevt;
    logic [CW-1:0]    held [NCH];
    logic [CW-1:0]    act  [NCH];
    logic [NCH-1:0]   match, wave;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign flag_wr = bus_wr && (bus_addr == A_FLAGS);
    assign mask_wr = bus_wr && (bus_addr == A_MASK);

    tmr_clk_sel #(.SYNC(2)) u_clk (
        .clk(clk), .rst(rst), .sel(ctrl_q.clk_sel),
        .tick(tick_in), .ext_pin(ext_clk_pin), .step(step)
    );

    tmr_count #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode),
        .top(ceiling(ctrl_q.mode, act[0])), .step(step),
        .set_wr(cnt_wr), .set_val(bus_wdata),
        .cnt(cnt), .up(up), .evt(cevt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_cmp_chan #(.W(CW)) u_ch (
            .clk(clk), .rst(rst), .mode(ctrl_q.mode),
            .wr(bus_wr && (bus_addr == A_CMPA + AW'(i))),
            .wdata(bus_wdata), .step(step), .cnt(cnt), .up(up),
            .wrap(cevt.wrap), .load(cevt.load), .wave_clr(ctrl_wr),
            .held(held[i]), .act(act[i]), .match(match[i]), .wave(wave[i])
        );
    end

    tmr_capture #(.W(CW), .SYNC(2), .FILT_LEN(4)) u_cap (
        .clk(clk), .rst(rst), .pin_sel(ctrl_q.pin_sel),
        .cmp_en(ctrl_q.cmp_en), .filt(ctrl_q.filt),
        .pin_a(cap_pin_a), .pin_b(cap_pin_b), .cmp_evt(cmp_evt_in),
        .cnt(cnt), .capt(capt), .hit(cap_hit)
    );

    always_comb begin
        flag_set        = '0;
        flag_set[F_OVF] = cevt.ovf;
        flag_set[F_MA]  = match[0];
        flag_set[F_MB]  = match[1];
        flag_set[F_CAP] = cap_hit;
        flag_clr        = flag_wr ? bus_wdata[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(bus_wdata[RW-1:0]);
            if (mask_wr) mask_q <= bus_wdata[NFLAG-1:0];
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(CW-RW){1'b0}}, ctrl_q};
            A_COUNT: bus_rdata = cnt;
            A_CMPA:  bus_rdata = held[0];
            A_CMPB:  bus_rdata = held[1];
            A_CAPT:  bus_rdata = capt;
            A_FLAGS: bus_rdata = {{(CW-NFLAG){1'b0}}, flags_q};
            A_MASK:  bus_rdata = {{(CW-NFLAG){1'b0}}, mask_q};
            default: bus_rdata = '0;
        endcase
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];
    assign irq    = |(flags_q & mask_q);
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
module tmr16_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  ctrl_bits,
    input logic [15:0] cnt,
    input logic        cnt_wr,
    input logic [3:0]  flags,
    input logic [3:0]  mask,
    input logic        flag_wr,
    input logic [15:0] capt,
    input logic        irq
);
    a_r2_hold_no_source: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_bits[2:0] == 3'd0 || ctrl_bits[2]) && !cnt_wr) |=> (cnt == $past(cnt)));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[4:3] == 2'd0 && !cnt_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

    a_r9_capture_flags: assert property (@(posedge clk) disable iff (rst)
        (capt != $past(capt)) |-> flags[3]);

    a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != 4'd0));

    a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == 4'd0) |-> !irq);
endmodule

bind tmr16_top tmr16_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_bits(ctrl_q), .cnt(cnt), .cnt_wr(cnt_wr),
    .flags(flags_q), .mask(mask_q), .flag_wr(flag_wr), .capt(capt), .irq(irq)
);

// File: tb/tmr16_top_test.sv
`timescale 1ns/1ps
module tmr16_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        tick_in = 1'b0, ext_clk_pin = 1'b0;
    logic        cap_pin_a = 1'b0, cap_pin_b = 1'b0, cmp_evt_in = 1'b0;
    logic        wave_a, wave_b, irq;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tmr16_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .ext_clk_pin(ext_clk_pin), .cap_pin_a(cap_pin_a), .cap_pin_b(cap_pin_b),
        .cmp_evt_in(cmp_evt_in), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] top;
        logic [15:0] start;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd0, 16'd0,      8'd5,  16'd5, 1'b0},
        '{2'd0, 16'd0, 16'hFFFE,   8'd3,  16'd1, 1'b1},
        '{2'd1, 16'd9, 16'd0,      8'd10, 16'd0, 1'b1},
        '{2'd1, 16'd9, 16'd0,      8'd13, 16'd3, 1'b1},
        '{2'd1, 16'd9, 16'd5,      8'd3,  16'd8, 1'b0},
        '{2'd2, 16'd4, 16'd0,      8'd4,  16'd4, 1'b0},
        '{2'd2, 16'd4, 16'd0,      8'd6,  16'd2, 1'b0},
        '{2'd2, 16'd4, 16'd0,      8'd9,  16'd1, 1'b1},
        '{2'd2, 16'd4, 16'd0,      8'd10, 16'd2, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk_pin = 1'b1; idle(3);
            ext_clk_pin = 1'b0; idle(3);
        end
        idle(4);
    endtask

    task automatic setup(input logic [1:0] mode, input logic [15:0] top, input logic [15:0] start);
        wr(3'd0, 16'h0000);
        wr(3'd2, top);
        wr(3'd1, start);
        wr(3'd5, 16'h000F);
        wr(3'd0, {11'd0, mode, 3'd1});
    endtask

    initial begin
        #600000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        string tag;
        idle(3);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 16'h0);
        rd(3'd1, v); check("R1 count", v, 16'h0);
        rd(3'd4, v); check("R1 capt", v, 16'h0);
        rd(3'd5, v); check("R1 flags", v, 16'h0);
        check("R1 outs", {13'd0, wave_a, wave_b, irq}, 16'h0);

        // table walk: R3 R4 R5 counting and overflow
        for (int k = 0; k < NV; k++) begin
            tag = (VECS[k].mode == 2'd0) ? "R3" : (VECS[k].mode == 2'd1) ? "R4" : "R5";
            setup(VECS[k].mode, VECS[k].top, VECS[k].start);
            ticks(int'(VECS[k].n));
            rd(3'd1, v); check({tag, " count"}, v, VECS[k].exp_cnt);
            rd(3'd5, v); check({tag, " overflow flag"}, v & 16'h1, {15'd0, VECS[k].exp_ovf});
        end

        // R2 no source holds, tick ignored by external modes
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0007);
        ticks(4); ext_pulses(2);
        rd(3'd1, v); check("R2 hold code 0", v, 16'h0007);
        wr(3'd0, 16'h0005); ticks(3);
        rd(3'd1, v); check("R2 hold code 5", v, 16'h0007);
        wr(3'd1, 16'h0020); wr(3'd0, 16'h0002);
        ticks(3); ext_pulses(3);
        rd(3'd1, v); check("R2 rising edges", v, 16'h0023);
        wr(3'd0, 16'h0003); ext_pulses(3);
        rd(3'd1, v); check("R2 falling edges", v, 16'h0026);

        // R7 R8 R12 compare flag, normal toggle, mask
        wr(3'd6, 16'h0000);
        wr(3'd0, 16'h0000); wr(3'd3, 16'h0003); wr(3'd1, 16'h0000);
        wr(3'd5, 16'h000F); wr(3'd0, 16'h0001);
        ticks(5);
        rd(3'd5, v); check("R7 match B flag", v & 16'h4, 16'h4);
        check("R8 normal toggle", {15'd0, wave_b}, 16'h1);
        check("R12 masked off", {15'd0, irq}, 16'h0);
        wr(3'd6, 16'h0004); idle(1);
        check("R12 mask on", {15'd0, irq}, 16'h1);
        wr(3'd5, 16'h0004);
        rd(3'd5, v); check("R11 clear", v & 16'h4, 16'h0);
        check("R12 irq drops", {15'd0, irq}, 16'h0);
        wr(3'd6, 16'h0000);

        // R11 set wins over clear
        wr(3'd0, 16'h0000); wr(3'd3, 16'h0003); wr(3'd1, 16'h0003);
        wr(3'd5, 16'h000F); wr(3'd0, 16'h0001);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 16'h0004; bus_wr = 1'b1; tick_in = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_in = 1'b0;
        rd(3'd5, v); check("R11 set wins", v & 16'h4, 16'h4);

        // R8 single ramp waveform
        wr(3'd0, 16'h0000); wr(3'd2, 16'd9); wr(3'd3, 16'd3); wr(3'd1, 16'd0);
        wr(3'd0, 16'h0009);
        ticks(10);
        rd(3'd1, v); check("R4 wrapped", v, 16'd0);
        check("R8 high at wrap", {15'd0, wave_b}, 16'h1);
        ticks(4);
        check("R8 low on match", {15'd0, wave_b}, 16'h0);

        // R6 buffered ceiling
        wr(3'd1, 16'd2); wr(3'd2, 16'd5);
        ticks(8);
        rd(3'd1, v); check("R6 old ceiling kept", v, 16'd0);
        ticks(5);
        rd(3'd1, v); check("R6 new ceiling", v, 16'd5);
        ticks(1);
        rd(3'd1, v); check("R6 wrap at new", v, 16'd0);

        // R8 up/down waveform
        wr(3'd0, 16'h0000); wr(3'd2, 16'd4); wr(3'd3, 16'd2); wr(3'd1, 16'd0);
        wr(3'd0, 16'h0011);
        ticks(7);
        rd(3'd1, v); check("R5 descending", v, 16'd1);
        check("R8 high on down match", {15'd0, wave_b}, 16'h1);

        // R9 capture sources
        wr(3'd0, 16'h0000); wr(3'd1, 16'h1234); wr(3'd5, 16'h000F);
        @(negedge clk); cap_pin_a = 1'b1; @(negedge clk); cap_pin_a = 1'b0; idle(5);
        rd(3'd4, v); check("R9 pin A value", v, 16'h1234);
        rd(3'd5, v); check("R9 pin A flag", v & 16'h8, 16'h8);
        wr(3'd5, 16'h000F); wr(3'd0, 16'h0020); wr(3'd1, 16'h0055);
        @(negedge clk); cap_pin_a = 1'b1; @(negedge clk); cap_pin_a = 1'b0; idle(5);
        rd(3'd5, v); check("R9 pin A ignored", v & 16'h8, 16'h0);
        rd(3'd4, v); check("R9 capt unchanged", v, 16'h1234);
        @(negedge clk); cap_pin_b = 1'b1; @(negedge clk); cap_pin_b = 1'b0; idle(5);
        rd(3'd4, v); check("R9 pin B value", v, 16'h0055);
        wr(3'd5, 16'h000F); wr(3'd0, 16'h0040); wr(3'd1, 16'h0777);
        @(negedge clk); cap_pin_a = 1'b1; cap_pin_b = 1'b1;
        @(negedge clk); cap_pin_a = 1'b0; cap_pin_b = 1'b0; idle(5);
        rd(3'd5, v); check("R9 pins ignored", v & 16'h8, 16'h0);
        @(negedge clk); cmp_evt_in = 1'b1; @(negedge clk); cmp_evt_in = 1'b0; idle(5);
        rd(3'd4, v); check("R9 comparator value", v, 16'h0777);

        // R10 noise filter
        wr(3'd0, 16'h0080); wr(3'd1, 16'h0ABC); wr(3'd5, 16'h000F);
        @(negedge clk); cap_pin_a = 1'b1; idle(2); cap_pin_a = 1'b0; idle(8);
        rd(3'd5, v); check("R10 glitch rejected", v & 16'h8, 16'h0);
        @(negedge clk); cap_pin_a = 1'b1; idle(6); cap_pin_a = 1'b0; idle(6);
        rd(3'd5, v); check("R10 steady accepted", v & 16'h8, 16'h8);
        rd(3'd4, v); check("R10 value", v, 16'h0ABC);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule